// File: doc/BRIEF.md
# Stateful Multiply-Accumulate Function Unit

This unit sits beside the integer ALU of a processor datapath and holds a 64-bit accumulator that is not part of the general-purpose register file. Each instruction supplies two 32-bit operands from the register read ports and a 3-bit opcode. Software first zeroes the hidden state. It then issues a run of signed multiply-accumulate operations. Finally it fetches the result one 32-bit half at a time through the write-back port.

Write-back happens only for the two read opcodes. The unit drives the selected half combinationally in the issue cycle. Every state change takes effect on the rising clock edge after the issue, and changes are applied in issue order. A command issued straight after a clear therefore starts from zero.

Top module: `mac_sfu`

## Requirements
- R1: An active-low asynchronous reset sets the accumulator to zero. A read issued after reset returns 0 in both halves.
- R2: With `valid_i` high and opcode 3'b001 (clear), the accumulator is zero from the next rising edge.
- R3: With `valid_i` high and opcode 3'b010 (accumulate), the signed two's-complement product `opa_i*opb_i` is sign-extended to 64 bits and added to the accumulator on the next rising edge.
- R4: Opcode 3'b011 drives accumulator bits 31:0 on `result_o` and raises `result_valid_o` in the same cycle, with no clock edge in between.
- R5: Opcode 3'b100 drives accumulator bits 63:32 on `result_o` and raises `result_valid_o` in the same cycle.
- R6: Opcode 3'b101 loads accumulator bits 31:0 from `opa_i` on the next edge and leaves bits 63:32 unchanged.
- R7: Opcodes 000, 001, 010 and 101 never raise `result_valid_o`. Whenever `result_valid_o` is low, `result_o` is zero.
- R8: While `valid_i` is low, the accumulator does not change and `result_valid_o` stays low, whatever the opcode is.
- R9: Back-to-back instructions are applied in issue order. An accumulate issued in the cycle right after a clear adds its product to zero.
- R10: The sum wraps modulo 2^64 and is never saturated.
- R11: Opcodes 3'b110 and 3'b111 behave as a no-operation: they cause no state change and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction issued this cycle |
| op_i | input | 3 | Opcode |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| result_o | output | 32 | Write-back data |
| result_valid_o | output | 1 | Write-back enable |

## Verification
The bench runs a behavioural 64-bit model beside the design and compares the outputs in every cycle. It targets the following corner cases:
- Negative operands and the most negative value squared. A design that extends the product with zeros instead of the sign corrupts the upper half.
- Sums that carry past bit 63. A design that saturates fails the wrap check.
- A clear followed at once by an accumulate, which exposes a design that applies the two in the wrong order.
- Accumulate, clear and write opcodes issued with `valid_i` low, and the two unused opcodes. These expose decode that ignores the valid signal or treats the spare codes as live commands.
- A low-half write, which exposes a design that also disturbs the upper half.

// File: rtl/mac_sfu_pkg.sv
package mac_sfu_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'b000,
    OP_CLR  = 3'b001,
    OP_MAC  = 3'b010,
    OP_RDLO = 3'b011,
    OP_RDHI = 3'b100,
    OP_WRLO = 3'b101
  } sfu_op_e;

  typedef struct packed {
    logic clr;
    logic mac;
    logic wrlo;
    logic rdlo;
    logic rdhi;
  } sfu_cmd_t;
endpackage

// File: rtl/mac_sfu_decode.sv
module mac_sfu_decode
  import mac_sfu_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  output sfu_cmd_t   cmd_o
);
  always_comb begin
    cmd_o = '0;
    if (valid_i) begin
      case (op_i)
        OP_CLR:  cmd_o.clr  = 1'b1;
        OP_MAC:  cmd_o.mac  = 1'b1;
        OP_WRLO: cmd_o.wrlo = 1'b1;
        OP_RDLO: cmd_o.rdlo = 1'b1;
        OP_RDHI: cmd_o.rdhi = 1'b1;
        default: cmd_o = '0;  // nop and spare codes
      endcase
    end
  end
endmodule

// File: rtl/mac_sfu_mult.sv
module mac_sfu_mult #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] prod_s;
  assign prod_s = $signed(a_i) * $signed(b_i);
  assign prod_o = prod_s;
endmodule

// File: rtl/mac_sfu_acc.sv
module mac_sfu_acc
  import mac_sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ACC_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sfu_cmd_t          cmd_i,
  input  logic [ACC_W-1:0]  prod_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (cmd_i.clr)       acc_d = '0;
    else if (cmd_i.mac)  acc_d = acc_q + prod_i;  // wraps mod 2^ACC_W
    else if (cmd_i.wrlo) acc_d = {acc_q[ACC_W-1:DATA_W], wdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.clr |=> acc_q == '0);  // R2
  AST_MAC_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.mac |=> acc_q == $past(acc_q) + $past(prod_i));  // R3
  AST_WRLO_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.wrlo |=> (acc_q[DATA_W-1:0] == $past(wdata_i))
                && (acc_q[ACC_W-1:DATA_W] == $past(acc_q[ACC_W-1:DATA_W])));  // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_i.clr || cmd_i.mac || cmd_i.wrlo) |=> $stable(acc_q));  // R8
endmodule

// File: rtl/mac_sfu.sv
module mac_sfu
  import mac_sfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);
  localparam int unsigned ACC_W   = 2 * DATA_W;
  localparam int unsigned N_WORDS = ACC_W / DATA_W;

  sfu_cmd_t          cmd;
  logic [ACC_W-1:0]  prod;
  logic [ACC_W-1:0]  acc;
  logic [DATA_W-1:0] acc_word [N_WORDS];

  mac_sfu_decode i_decode (
    .valid_i (valid_i),
    .op_i    (op_i),
    .cmd_o   (cmd)
  );

  mac_sfu_mult #(.DATA_W(DATA_W)) i_mult (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .prod_o (prod)
  );

  mac_sfu_acc #(.DATA_W(DATA_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .prod_i  (prod),
    .wdata_i (opa_i),
    .acc_o   (acc)
  );

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    assign acc_word[g] = acc[g*DATA_W +: DATA_W];
  end

  always_comb begin
    result_o = '0;
    if (cmd.rdlo)      result_o = acc_word[0];
    else if (cmd.rdhi) result_o = acc_word[N_WORDS-1];
  end
  assign result_valid_o = cmd.rdlo | cmd.rdhi;

  AST_WB_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> valid_i && (op_i == OP_RDLO || op_i == OP_RDHI));  // R7
  AST_WB_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !result_valid_o |-> result_o == '0);  // R7
  AST_RDHI_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_RDHI) |-> result_valid_o && result_o == acc[ACC_W-1:ACC_W-DATA_W]);  // R5
endmodule

// File: tb/test_mac_sfu.sv
module test_mac_sfu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        result_valid;

  int total = 0;
  int bad = 0;
  logic [63:0] m_acc = '0;

  always #5 clk = ~clk;

  mac_sfu i_mac_sfu (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .result_o(result), .result_valid_o(result_valid)
  );

  task automatic issue(input logic v, input logic [2:0] o,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    logic        e_v;
    logic [31:0] e_r;
    longint      p;
    @(negedge clk);
    valid = v; op = o; opa = a; opb = b;
    #1;
    e_v = v && (o == 3'b011 || o == 3'b100);
    e_r = !e_v ? 32'h0 : (o == 3'b011 ? m_acc[31:0] : m_acc[63:32]);
    total++;
    if (result_valid !== e_v || result !== e_r) begin
      bad++;
      $display("FAIL %s: op=%0b valid=%0b got res=%h v=%0b exp res=%h v=%0b",
               tag, o, v, result, result_valid, e_r, e_v);
    end
    @(posedge clk);
    #1;
    if (v) begin
      case (o)
        3'b001: m_acc = '0;
        3'b010: begin
          p = longint'($signed(a)) * longint'($signed(b));
          m_acc = m_acc + 64'(p);
        end
        3'b101: m_acc[31:0] = a;
        default: ;
      endcase
    end
  endtask

  task automatic read_both(input string tag);
    issue(1'b1, 3'b011, 32'h0, 32'h0, tag);
    issue(1'b1, 3'b100, 32'h0, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    read_both("R1");
    // plain signed accumulate, R3 and R4/R5 readback
    issue(1'b1, 3'b010, 32'd7, 32'd9, "R3");
    issue(1'b1, 3'b010, 32'hFFFF_FFFD, 32'd5, "R3");
    read_both("R4");
    issue(1'b1, 3'b010, 32'h8000_0000, 32'h8000_0000, "R3");
    read_both("R5");
    issue(1'b1, 3'b010, 32'h7FFF_FFFF, 32'h8000_0000, "R3");
    read_both("R5");
    // R7: non-read opcodes never write back
    issue(1'b1, 3'b000, 32'h1234, 32'h5678, "R7");
    // R8: valid low blocks everything
    issue(1'b0, 3'b001, 32'h0, 32'h0, "R8");
    issue(1'b0, 3'b010, 32'h1000, 32'h1000, "R8");
    issue(1'b0, 3'b101, 32'hDEAD_BEEF, 32'h0, "R8");
    issue(1'b0, 3'b011, 32'h0, 32'h0, "R8");
    read_both("R8");
    // R11: spare opcodes
    issue(1'b1, 3'b110, 32'h55, 32'h66, "R11");
    issue(1'b1, 3'b111, 32'h55, 32'h66, "R11");
    read_both("R11");
    // R2 clear then R9 back-to-back accumulate
    issue(1'b1, 3'b001, 32'h0, 32'h0, "R2");
    read_both("R2");
    issue(1'b1, 3'b010, 32'd3, 32'd4, "R3");
    issue(1'b1, 3'b001, 32'h0, 32'h0, "R9");
    issue(1'b1, 3'b010, 32'hFFFF_FFFF, 32'd11, "R9");
    read_both("R9");
    // R6 low-half write keeps upper half
    issue(1'b1, 3'b101, 32'hCAFE_F00D, 32'h0, "R6");
    read_both("R6");
    // R10 wrap past 2^64
    issue(1'b1, 3'b001, 32'h0, 32'h0, "R10");
    issue(1'b1, 3'b010, 32'hFFFF_FFFF, 32'd1, "R10");
    issue(1'b1, 3'b101, 32'hFFFF_FFFF, 32'h0, "R10");
    issue(1'b1, 3'b010, 32'd2, 32'd3, "R10");
    read_both("R10");
    // mixed sweep with computed operands
    for (int i = 0; i < 40; i++) begin
      issue(1'b1, 3'b010, 32'(i * 32'h9E37_79B9), 32'(32'h7F4A_7C15 - i * 977), "R3");
      if (i % 8 == 7) read_both("R4");
    end
    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0; m_acc = '0;
    @(negedge clk); rst_n = 1'b1;
    read_both("R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule